// File: doc/BRIEF.md
# Infrared Unit-Slot Frame Transmitter

This block turns a 31-bit scancode into an infrared drive level. Every part of the frame lasts one fixed time unit, called a slot. A frame opens with a single header pulse. It then walks the scancode from its top bit down to bit 0 and sends two slots per bit: first an integrity slot, then a data slot. A quiet trailing slot closes the frame. The integrity slots follow a rule based on pairs of adjacent bits, and that rule applies only at a fixed set of bit positions. A receiver can therefore reject frames that were corrupted on the way.

A one-cycle start request launches a frame when the block is idle. `busy` stays high for the whole frame, and `done` pulses for one cycle as `busy` falls. An internal prescaler divides the clock into 1 µs ticks, and a unit counter groups the ticks into slots (416 µs by default). The pulse level can go out as a steady high, or it can be gated by a 38 kHz square wave that an internal clock divider produces.

Top module: `ir_slot_encoder`

## Requirements
- R1: After a synchronous reset, `ir_out`, `busy` and `done` are all 0.
- R2: A `start` sampled while idle raises `busy` on the next cycle. The frame then lasts 64 slots of exactly TICK_DIV*UNIT_US cycles each.
- R3: Slot 0 is the header and is always a pulse (`ir_out` active).
- R4: Slot 2k+1 is the integrity slot for bit position p=30-k. At p in {9..14, 16..22, 24, 25, 30} it is a pulse exactly when code bit p and code bit p+1 are both 0. Bit 31 counts as 0.
- R5: At every other position (0..8, 15, 23, 26..29) the integrity slot is a space (`ir_out`=0).
- R6: Slot 2k+2 is the data slot for position p=30-k. It is a pulse when code bit p is 0 and a space when it is 1.
- R7: Slot 63 is a space. At the end of that slot, `busy` falls and `done` is high for exactly one cycle.
- R8: A `start` that arrives while `busy` is high has no effect. The frame in progress keeps its original scancode and timing.
- R9: With `carrier_en`=1, each pulse cycle outputs a square wave. The wave is high during the first CARRIER_HALF cycles of the frame and then toggles every CARRIER_HALF cycles. With `carrier_en`=0, each pulse cycle outputs a steady 1.
- R10: While `busy` is low, `ir_out` is 0.
- R11: A reset asserted during a frame aborts it and returns the block to idle. A later start produces a complete, correct frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Frame launch request, one cycle |
| scancode | input | 31 | Code to send, sampled on an accepted start |
| carrier_en | input | 1 | 1: gate pulses with the carrier; 0: steady pulse level |
| ir_out | output | 1 | Infrared drive level (1 = pulse) |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame strobe |

## Verification
The bench checks the output in every cycle of each frame against a model built from the slot rules. The all-zeros scancode makes every masked integrity slot pulse, so a wrong mask or a missing bit-31 guard at position 30 would show up as misplaced pulses. The all-ones code and the alternating code expose a design that inverts the data polarity, or one that looks at the wrong neighbour for the pair rule. A start request injected mid-frame catches a design that reloads its code or restarts its slot count. A reset applied mid-frame, followed by a fresh frame, catches state that survives the abort. The carrier run checks the phase and half-period of the wave, so a divider that drifts or runs free across frames would be reported.

// File: rtl/ir_slot_pkg.sv
package ir_slot_pkg;

    localparam int CODE_W      = 31;
    localparam int SLOT_COUNT  = 2 * CODE_W + 2;
    localparam int SLOT_IDX_W  = $clog2(SLOT_COUNT);
    localparam int POS_W       = $clog2(CODE_W);

    // Positions whose integrity slot carries the pair rule
    localparam logic [CODE_W-1:0] PAIR_MASK = 31'h437F7E00;

    typedef enum logic [1:0] {
        SLOT_HEAD,
        SLOT_CHECK,
        SLOT_DATA,
        SLOT_TAIL
    } slot_kind_e;

    typedef struct packed {
        slot_kind_e       kind;
        logic [POS_W-1:0] pos;
    } slot_desc_t;

    function automatic slot_desc_t decode_slot(logic [SLOT_IDX_W-1:0] idx);
        slot_desc_t d;
        logic [SLOT_IDX_W-1:0] k;
        k = (idx - SLOT_IDX_W'(1)) >> 1;
        d.pos = POS_W'(SLOT_IDX_W'(CODE_W - 1) - k);
        if (idx == '0)
            d.kind = SLOT_HEAD;
        else if (idx == SLOT_IDX_W'(SLOT_COUNT - 1))
            d.kind = SLOT_TAIL;
        else if (idx[0])
            d.kind = SLOT_CHECK;
        else
            d.kind = SLOT_DATA;
        return d;
    endfunction

    function automatic logic slot_level(slot_desc_t d, logic [CODE_W-1:0] code);
        logic [CODE_W:0] ext;
        logic            lvl;
        ext = {1'b0, code};
        case (d.kind)
            SLOT_HEAD:  lvl = 1'b1;
            SLOT_CHECK: lvl = PAIR_MASK[d.pos] && !ext[d.pos]
                              && !ext[6'(d.pos) + 6'd1];
            SLOT_DATA:  lvl = !ext[d.pos];
            default:    lvl = 1'b0;
        endcase
        return lvl;
    endfunction

endpackage

// File: rtl/ir_unit_timer.sv
module ir_unit_timer #(
    parameter int TICK_DIV = 125,
    parameter int UNIT_US  = 416
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic slot_end
);
    localparam int TW = $clog2(TICK_DIV + 1);
    localparam int UW = $clog2(UNIT_US + 1);
    localparam logic [TW-1:0] TICK_LAST = TW'(TICK_DIV - 1);
    localparam logic [UW-1:0] UNIT_LAST = UW'(UNIT_US - 1);

    logic [TW-1:0] tick_cnt;
    logic [UW-1:0] unit_cnt;
    logic          tick;

    assign tick     = en && (tick_cnt == TICK_LAST);
    assign slot_end = tick && (unit_cnt == UNIT_LAST);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            tick_cnt <= '0;
            unit_cnt <= '0;
        end else if (tick) begin
            tick_cnt <= '0;
            unit_cnt <= (unit_cnt == UNIT_LAST) ? '0 : unit_cnt + UW'(1);
        end else begin
            tick_cnt <= tick_cnt + TW'(1);
        end
    end

    // R2
    slot_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        slot_end |=> (tick_cnt == '0 && unit_cnt == '0));

    // R2
    idle_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (unit_cnt == '0 && !slot_end));

endmodule

// File: rtl/ir_carrier_gen.sv
module ir_carrier_gen #(
    parameter int HALF = 1645
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic wave
);
    localparam int CW = $clog2(HALF + 1);
    localparam logic [CW-1:0] HALF_LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt  <= '0;
            wave <= 1'b1;
        end else if (cnt == HALF_LAST) begin
            cnt  <= '0;
            wave <= !wave;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

    // R9
    phase_start_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> wave);

endmodule

// File: rtl/ir_slot_encoder.sv
module ir_slot_encoder
    import ir_slot_pkg::*;
#(
    parameter int TICK_DIV     = 125,
    parameter int UNIT_US      = 416,
    parameter int CARRIER_HALF = 1645
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CODE_W-1:0] scancode,
    input  logic              carrier_en,
    output logic              ir_out,
    output logic              busy,
    output logic              done
);
    localparam logic [SLOT_IDX_W-1:0] LAST_SLOT = SLOT_IDX_W'(SLOT_COUNT - 1);

    logic [SLOT_IDX_W-1:0] slot_idx;
    logic [CODE_W-1:0]     code_q;
    logic                  slot_end;
    logic                  wave;
    logic                  pulse_lvl;
    slot_desc_t            cur_slot;

    ir_unit_timer #(.TICK_DIV(TICK_DIV), .UNIT_US(UNIT_US)) u_timer (
        .clk(clk), .rst(rst), .en(busy), .slot_end(slot_end)
    );

    ir_carrier_gen #(.HALF(CARRIER_HALF)) u_carrier (
        .clk(clk), .rst(rst), .en(busy), .wave(wave)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            done     <= 1'b0;
            slot_idx <= '0;
            code_q   <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy     <= 1'b1;
                    slot_idx <= '0;
                    code_q   <= scancode;
                end
            end else if (slot_end) begin
                if (slot_idx == LAST_SLOT) begin
                    busy     <= 1'b0;
                    done     <= 1'b1;
                    slot_idx <= '0;
                end else begin
                    slot_idx <= slot_idx + SLOT_IDX_W'(1);
                end
            end
        end
    end

    always_comb begin
        cur_slot  = decode_slot(slot_idx);
        pulse_lvl = slot_level(cur_slot, code_q);
        ir_out    = busy && pulse_lvl && (carrier_en ? wave : 1'b1);
    end

    // R10
    idle_space_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !ir_out);

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7
    busy_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R8
    code_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(code_q));

    // R3
    head_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ir_out);

endmodule

// File: tb/ir_slot_encoder_test.sv
module ir_slot_encoder_test;
    localparam int TD   = 2;
    localparam int UU   = 4;
    localparam int CH   = 3;
    localparam int SLOT = TD * UU;
    localparam int NSL  = 64;
    localparam int TOTAL = NSL * SLOT;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [30:0] scancode = '0;
    logic        carrier_en = 1'b0;
    logic        ir_out, busy, done;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    ir_slot_encoder #(.TICK_DIV(TD), .UNIT_US(UU), .CARRIER_HALF(CH)) uut (
        .clk(clk), .rst(rst), .start(start), .scancode(scancode),
        .carrier_en(carrier_en), .ir_out(ir_out), .busy(busy), .done(done)
    );

    function automatic bit pair_pos(int p);
        return (p == 30) || (p == 24) || (p == 25) ||
               (p >= 16 && p <= 22) || (p >= 9 && p <= 14);
    endfunction

    function automatic bit model_level(int s, logic [30:0] c);
        int p;
        bit hi;
        if (s == 0) return 1'b1;
        if (s == NSL - 1) return 1'b0;
        p = 30 - (s - 1) / 2;
        if ((s % 2) == 1) begin
            hi = (p == 30) ? 1'b0 : c[p + 1];
            return pair_pos(p) && !c[p] && !hi;
        end
        return !c[p];
    endfunction

    function automatic string slot_tag(int s);
        int p;
        if (s == 0) return "R3";
        if (s == NSL - 1) return "R7";
        p = 30 - (s - 1) / 2;
        if ((s % 2) == 0) return "R6";
        return pair_pos(p) ? "R4" : "R5";
    endfunction

    task automatic check(string tag, logic act, logic exp, string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
        end
    endtask

    task automatic launch(logic [30:0] c);
        @(negedge clk);
        scancode = c;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        scancode = ~c;
    endtask

    // Runs one frame; checks every cycle. inj >= 0 drives a stray start at that cycle.
    task automatic run_frame(logic [30:0] c, logic car, int inj);
        int s;
        bit lvl;
        carrier_en = car;
        launch(c);
        for (int n = 0; n < TOTAL; n++) begin
            s = n / SLOT;
            lvl = model_level(s, c);
            if (car) lvl = lvl && ((n / CH) % 2 == 0);
            check("R2", busy, 1'b1, $sformatf("busy at cycle %0d", n));
            check(car ? "R9" : slot_tag(s), ir_out, lvl,
                  $sformatf("ir_out slot %0d cycle %0d", s, n));
            if (n == inj) begin
                scancode = ~c;
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        check("R7", busy, 1'b0, "busy after tail");
        check("R7", done, 1'b1, "done at end");
        check("R10", ir_out, 1'b0, "ir_out idle");
        @(negedge clk);
        check("R7", done, 1'b0, "done one cycle");
    endtask

    task automatic test_reset_state();
        check("R1", ir_out, 1'b0, "ir_out reset");
        check("R1", busy, 1'b0, "busy reset");
        check("R1", done, 1'b0, "done reset");
    endtask

    task automatic test_abort();
        carrier_en = 1'b0;
        launch(31'h1234_5678);
        repeat (50) @(negedge clk);
        check("R11", busy, 1'b1, "busy before abort");
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check("R11", busy, 1'b0, "busy after abort");
        check("R11", ir_out, 1'b0, "ir_out after abort");
        check("R11", done, 1'b0, "done after abort");
        repeat (3) @(negedge clk);
        check("R10", ir_out, 1'b0, "ir_out idle after abort");
        run_frame(31'h0F0F_0F0F, 1'b0, -1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset_state();
        run_frame(31'h0000_0000, 1'b0, -1);
        run_frame(31'h7FFF_FFFF, 1'b0, -1);
        run_frame(31'h2991_15B7, 1'b0, -1);
        run_frame(31'h2AAA_AAAA, 1'b0, -1);
        run_frame(31'h5555_5555, 1'b1, -1);
        run_frame(31'h0000_0000, 1'b1, -1);
        run_frame(31'h4000_0001, 1'b0, 100); // R8 stray start mid-frame
        test_abort();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule